// File: doc/BRIEF.md
# Amplifier Startup Sequencer and Serial Control Writer

This block sits on the host side of a headphone amplifier. After the system reset is released, it walks the amplifier's reset, power-down and mute lines through a fixed, pop-free order. It then sends a 16-bit configuration word over a three-wire link (serial clock, serial data, latch strobe). It holds hardware mute for a long settling interval, and finally releases mute and raises `done`.

From then on, software or another block can send further 16-bit control words, such as volume or mode changes, through a valid/ready port. The port accepts one word at a time. `wr_ready` stays low from the cycle after acceptance until the latch strobe of that frame has returned low and the tail gap has elapsed.

All widths and intervals are counted in system clock cycles:
- `RST_CYC` sets how long the amplifier reset is held.
- `WAKE_CYC` sets the gap between reset release and power-down release.
- `HALF` sets every serial phase: data setup, data hold, clock high, clock low, latch setup, latch high and the tail gap.
- `MUTE_CYC` sets the mute delay. It can be shortened for simulation.

The sequencer states are:
- `SQ_BOOT`: the one-cycle entry state.
- `SQ_HOLD_RST`: the amplifier is held in reset.
- `SQ_WAKE`: reset is released, power-down is still active.
- `SQ_CFG`: power-down is released and the configuration frame is sent.
- `SQ_SETTLE`: the mute delay runs.
- `SQ_IDLE`: mute is released and writes are accepted.
- `SQ_XFER`: a runtime frame is being sent.

The sequencer transitions are:
- `SQ_BOOT` to `SQ_HOLD_RST` unconditionally.
- `SQ_HOLD_RST` to `SQ_WAKE` when the timer expires.
- `SQ_WAKE` to `SQ_CFG` when the timer expires; this also starts the configuration frame.
- `SQ_CFG` to `SQ_SETTLE` when the frame finishes.
- `SQ_SETTLE` to `SQ_IDLE` when the timer expires.
- `SQ_IDLE` to `SQ_XFER` on `wr_valid`.
- `SQ_XFER` to `SQ_IDLE` when the frame finishes.

The frame engine states are:
- `TX_IDLE`: no frame in progress.
- `TX_LOW`: data is presented while the clock is low.
- `TX_HIGH`: the clock is high.
- `TX_GAP`: the clock is low before the strobe.
- `TX_LATCH`: the strobe is high.
- `TX_TAIL`: the strobe is low after the frame.

The frame engine transitions are:
- `TX_IDLE` to `TX_LOW` on start.
- `TX_LOW` to `TX_HIGH` after `HALF` cycles.
- `TX_HIGH` to `TX_LOW` after `HALF` cycles, or to `TX_GAP` after the last bit.
- `TX_GAP` to `TX_LATCH` after `HALF` cycles.
- `TX_LATCH` to `TX_TAIL` after `HALF` cycles.
- `TX_TAIL` to `TX_IDLE` after `HALF` cycles.

Top module: `amp_boot_ctl`

## Requirements
- R1: While `rst_n` is low, `amp_rst_n`, `amp_pwr_n`, `amp_mute_n`, `ser_clk`, `ser_dat`, `ser_latch`, `wr_ready` and `done` are all low.
- R2: After `rst_n` rises, `amp_rst_n` stays low for at least `RST_CYC` cycles and then rises.
- R3: `amp_pwr_n` rises no sooner than `WAKE_CYC` cycles after `amp_rst_n` rises, and is high before the first rising edge of `ser_clk`.
- R4: A frame is 16 data bits, most significant bit first. The amplifier captures each bit on a rising edge of `ser_clk`, and the frame is followed by one rising edge of `ser_latch`. The first frame after reset carries `init_word`.
- R5: `ser_dat` is stable for at least `HALF` cycles before and at least `HALF` cycles after every rising edge of `ser_clk`. `ser_clk` high and low phases last at least `HALF` cycles each.
- R6: `ser_clk` is low whenever `ser_latch` is high. `ser_latch` rises at least `HALF` cycles after the last falling edge of `ser_clk` and stays high for at least `HALF` cycles. The next rising edge of `ser_clk` comes at least `HALF` cycles after `ser_latch` falls.
- R7: `amp_mute_n` rises no sooner than `MUTE_CYC` cycles after the configuration frame's latch falls. `done` rises in the same cycle.
- R8: `wr_ready` is high only while mute is released and no frame is in progress. A word is accepted when `wr_valid` and `wr_ready` are both high at a clock edge, and `wr_ready` is low in the following cycle.
- R9: `wr_valid` asserted while `wr_ready` is low is ignored: no frame results from it.
- R10: Once `amp_mute_n` has risen, `amp_rst_n`, `amp_pwr_n`, `amp_mute_n` and `done` remain high across all later writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| init_word | input | 16 | Configuration word sent during startup |
| wr_valid | input | 1 | Runtime write request |
| wr_data | input | 16 | Runtime control word |
| wr_ready | output | 1 | High when a runtime write can be accepted |
| amp_rst_n | output | 1 | Amplifier reset, active low |
| amp_pwr_n | output | 1 | Amplifier power-down, active low |
| amp_mute_n | output | 1 | Amplifier hardware mute, active low |
| ser_clk | output | 1 | Serial clock to the amplifier |
| ser_dat | output | 1 | Serial data to the amplifier |
| ser_latch | output | 1 | Latch strobe to the amplifier |
| done | output | 1 | Startup sequence complete |

## Verification
The bench targets four corner cases:
- **Control-line order and gaps.** A sequencer that skipped the wake gap, or let power-down release after the first serial clock, would show a too-short reset-to-power gap or a clock edge while power-down is still active.
- **Serial timing.** The bench measures setup, hold, clock phase widths and latch spacing on every edge. An off-by-one in the phase counter shows up as a window of `HALF-1`.
- **Frame content.** The bench decodes every frame bit by bit, using all-zero, all-one, alternating-ends and random words. A bit-order or bit-count error shows up as a wrong word or a count other than 16.
- **Ignored requests.** The bench drives `wr_valid` during startup and during frames. A design that accepted such requests would emit extra frames or raise ready early.

// File: rtl/amp_boot_pkg.sv
package amp_boot_pkg;

    typedef enum logic [2:0] {
        SQ_BOOT,
        SQ_HOLD_RST,
        SQ_WAKE,
        SQ_CFG,
        SQ_SETTLE,
        SQ_IDLE,
        SQ_XFER
    } seq_state_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_LOW,
        TX_HIGH,
        TX_GAP,
        TX_LATCH,
        TX_TAIL
    } tx_state_t;

    function automatic int unsigned max_of3(input int unsigned a, input int unsigned b,
                                            input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/amp_wait_timer.sv
module amp_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/amp_frame_tx.sv
module amp_frame_tx
    import amp_boot_pkg::*;
#(
    parameter int W    = 16,
    parameter int HALF = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] word,
    output logic         ser_clk,
    output logic         ser_dat,
    output logic         ser_latch,
    output logic         busy,
    output logic         fin
);
    localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = (W > 2) ? $clog2(W) : 1;

    tx_state_t      st, nxt;
    logic [PW-1:0]  cnt;
    logic [BW-1:0]  bitn;
    logic [W-1:0]   shreg;
    logic           phase_end;
    logic           last_bit;

    assign phase_end = (cnt == PW'(HALF - 1));
    assign last_bit  = (bitn == BW'(W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= TX_IDLE;
        else
            st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            TX_IDLE:  if (start)     nxt = TX_LOW;
            TX_LOW:   if (phase_end) nxt = TX_HIGH;
            TX_HIGH:  if (phase_end) nxt = last_bit ? TX_GAP : TX_LOW;
            TX_GAP:   if (phase_end) nxt = TX_LATCH;
            TX_LATCH: if (phase_end) nxt = TX_TAIL;
            TX_TAIL:  if (phase_end) nxt = TX_IDLE;
            default:                 nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else if (st == TX_IDLE) begin
            cnt <= '0;
            if (start) begin
                shreg <= word;
                bitn  <= '0;
            end
        end else begin
            cnt <= phase_end ? '0 : cnt + 1'b1;
            if (st == TX_HIGH && phase_end && !last_bit) begin
                shreg <= {shreg[W-2:0], 1'b0};
                bitn  <= bitn + 1'b1;
            end
        end
    end

    always_comb begin
        ser_clk   = (st == TX_HIGH);
        ser_latch = (st == TX_LATCH);
        ser_dat   = shreg[W-1];
        busy      = (st != TX_IDLE);
        fin       = (st == TX_TAIL) && phase_end;
    end
endmodule

// File: rtl/amp_boot_ctl.sv
module amp_boot_ctl
    import amp_boot_pkg::*;
#(
    parameter int W        = 16,
    parameter int RST_CYC  = 10,
    parameter int WAKE_CYC = 100,
    parameter int HALF     = 5,
    parameter int MUTE_CYC = 250000000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] init_word,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    output logic         wr_ready,
    output logic         amp_rst_n,
    output logic         amp_pwr_n,
    output logic         amp_mute_n,
    output logic         ser_clk,
    output logic         ser_dat,
    output logic         ser_latch,
    output logic         done
);
    localparam int unsigned TMAX = max_of3(RST_CYC, WAKE_CYC, MUTE_CYC);
    localparam int TW = $clog2(TMAX + 1);

    seq_state_t    st, nxt;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_zero;
    logic          tx_start;
    logic [W-1:0]  tx_word;
    logic          tx_busy;
    logic          tx_fin;

    amp_wait_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .value (t_val),
        .zero  (t_zero)
    );

    amp_frame_tx #(.W(W), .HALF(HALF)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tx_start),
        .word      (tx_word),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_latch (ser_latch),
        .busy      (tx_busy),
        .fin       (tx_fin)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= SQ_BOOT;
        else
            st <= nxt;
    end

    always_comb begin
        nxt      = st;
        t_load   = 1'b0;
        t_val    = '0;
        tx_start = 1'b0;
        tx_word  = wr_data;
        unique case (st)
            SQ_BOOT: begin
                t_load = 1'b1;
                t_val  = TW'(RST_CYC - 1);
                nxt    = SQ_HOLD_RST;
            end
            SQ_HOLD_RST: if (t_zero) begin
                t_load = 1'b1;
                t_val  = TW'(WAKE_CYC - 1);
                nxt    = SQ_WAKE;
            end
            SQ_WAKE: if (t_zero) begin
                tx_start = 1'b1;
                tx_word  = init_word;
                nxt      = SQ_CFG;
            end
            SQ_CFG: if (tx_fin) begin
                t_load = 1'b1;
                t_val  = TW'(MUTE_CYC - 1);
                nxt    = SQ_SETTLE;
            end
            SQ_SETTLE: if (t_zero) nxt = SQ_IDLE;
            SQ_IDLE: if (wr_valid && !tx_busy) begin
                tx_start = 1'b1;
                nxt      = SQ_XFER;
            end
            SQ_XFER: if (tx_fin) nxt = SQ_IDLE;
            default: nxt = SQ_BOOT;
        endcase
    end

    always_comb begin
        amp_rst_n  = 1'b0;
        amp_pwr_n  = 1'b0;
        amp_mute_n = 1'b0;
        wr_ready   = 1'b0;
        done       = 1'b0;
        unique case (st)
            SQ_BOOT, SQ_HOLD_RST: ;
            SQ_WAKE: amp_rst_n = 1'b1;
            SQ_CFG, SQ_SETTLE: begin
                amp_rst_n = 1'b1;
                amp_pwr_n = 1'b1;
            end
            SQ_IDLE, SQ_XFER: begin
                amp_rst_n  = 1'b1;
                amp_pwr_n  = 1'b1;
                amp_mute_n = 1'b1;
                done       = 1'b1;
                wr_ready   = (st == SQ_IDLE) && !tx_busy;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/amp_boot_chk.sv
module amp_boot_chk #(
    parameter int HALF = 5
) (
    input logic clk,
    input logic rst_n,
    input logic wr_ready,
    input logic amp_rst_n,
    input logic amp_pwr_n,
    input logic amp_mute_n,
    input logic ser_clk,
    input logic ser_dat,
    input logic ser_latch
);
    localparam int SW = $clog2(HALF + 2);

    logic [SW-1:0] stab;
    logic          prev_dat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stab     <= '0;
            prev_dat <= 1'b0;
        end else begin
            prev_dat <= ser_dat;
            if (ser_dat != prev_dat)
                stab <= '0;
            else if (stab != SW'(HALF))
                stab <= stab + 1'b1;
        end
    end

    // R6
    latch_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_latch |-> !ser_clk);

    // R8
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!ser_clk && !ser_latch && amp_mute_n));

    // R3
    pwr_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(amp_pwr_n) |-> amp_rst_n);

    // R3
    clk_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> amp_pwr_n);

    // R7
    mute_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(amp_mute_n) |-> (amp_rst_n && amp_pwr_n && !ser_latch));

    // R10
    mute_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        amp_mute_n |=> (amp_mute_n && amp_rst_n && amp_pwr_n));

    // R5
    dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

    // R5
    dat_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> (stab >= SW'(HALF - 1)));
endmodule

bind amp_boot_ctl amp_boot_chk #(.HALF(HALF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ready   (wr_ready),
    .amp_rst_n  (amp_rst_n),
    .amp_pwr_n  (amp_pwr_n),
    .amp_mute_n (amp_mute_n),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .ser_latch  (ser_latch)
);

// File: tb/sim_amp_boot_ctl.sv
module sim_amp_boot_ctl;
    localparam int RC = 30;
    localparam int WC = 8;
    localparam int HF = 13;
    localparam int MC = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] init_word = 16'hA5C3;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ready, amp_rst_n, amp_pwr_n, amp_mute_n;
    logic        ser_clk, ser_dat, ser_latch, done;

    always #2 clk = ~clk;

    amp_boot_ctl #(.W(16), .RST_CYC(RC), .WAKE_CYC(WC), .HALF(HF), .MUTE_CYC(MC)) u0 (
        .clk(clk), .rst_n(rst_n), .init_word(init_word), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_ready(wr_ready), .amp_rst_n(amp_rst_n),
        .amp_pwr_n(amp_pwr_n), .amp_mute_n(amp_mute_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_latch(ser_latch), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    logic [15:0] expq[$];

    function automatic int frame_len();
        return 16 * 2 * HF + 3 * HF;
    endfunction

    function automatic bit wide_enough(input int age);
        return age >= HF;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // monitor state
    logic p_clk = 0, p_dat = 0, p_lat = 0, p_rst = 0, p_pwr = 0, p_mute = 0;
    int dat_age = 1000, rise_age = 1000, fall_age = 1000, lrise_age = 1000, lfall_age = 1000;
    int cyc = 0, rst_low = 0, rst_rise_cyc = 0, cfg_fall_cyc = -1;
    int nbits = 0, nframes = 0, frames_pre = 0;
    logic [15:0] sh = '0;
    bit first_clk = 0, done_seen = 0, sticky_bad = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            // R1
            chk(!amp_rst_n && !amp_pwr_n && !amp_mute_n, "R1 ctl", {amp_rst_n, amp_pwr_n, amp_mute_n}, 0);
            chk(!ser_clk && !ser_dat && !ser_latch, "R1 ser", {ser_clk, ser_dat, ser_latch}, 0);
            chk(!wr_ready && !done, "R1 rdy", {wr_ready, done}, 0);
        end else begin
            automatic bit e_dc = (ser_dat != p_dat);
            automatic bit e_cr = ser_clk && !p_clk;
            automatic bit e_cf = !ser_clk && p_clk;
            automatic bit e_lr = ser_latch && !p_lat;
            automatic bit e_lf = !ser_latch && p_lat;
            cyc++;
            dat_age   = e_dc ? 0 : (dat_age < 1000 ? dat_age + 1 : dat_age);
            rise_age  = e_cr ? 0 : (rise_age < 1000 ? rise_age + 1 : rise_age);
            fall_age  = e_cf ? 0 : (fall_age < 1000 ? fall_age + 1 : fall_age);
            lrise_age = e_lr ? 0 : (lrise_age < 1000 ? lrise_age + 1 : lrise_age);
            lfall_age = e_lf ? 0 : (lfall_age < 1000 ? lfall_age + 1 : lfall_age);
            if (!amp_rst_n) rst_low++;
            if (amp_rst_n && !p_rst) begin
                chk(rst_low >= RC, "R2 reset width", rst_low, RC);
                rst_rise_cyc = cyc;
            end
            if (amp_pwr_n && !p_pwr)
                chk(cyc - rst_rise_cyc >= WC, "R3 wake gap", cyc - rst_rise_cyc, WC);
            if (e_cr) begin
                chk(wide_enough(dat_age), "R5 setup", dat_age, HF);
                chk(wide_enough(fall_age), "R5 clk low", fall_age, HF);
                chk(wide_enough(lfall_age), "R6 latch to clk", lfall_age, HF);
                if (!first_clk) chk(amp_pwr_n, "R3 pwr before clk", amp_pwr_n, 1);
                first_clk = 1;
                sh = {sh[14:0], ser_dat};
                nbits++;
            end
            if (e_dc) chk(wide_enough(rise_age), "R5 hold", rise_age, HF);
            if (e_cf) chk(wide_enough(rise_age), "R5 clk high", rise_age, HF);
            if (ser_latch) chk(!ser_clk, "R6 exclusive", ser_clk, 0);
            if (e_lr) begin
                chk(wide_enough(fall_age), "R6 latch setup", fall_age, HF);
                chk(nbits == 16, "R4 bit count", nbits, 16);
                if (expq.size() == 0) chk(0, "R9 unexpected frame", sh, 0);
                else begin
                    automatic logic [15:0] e = expq.pop_front();
                    chk(sh == e, "R4 frame word", sh, e);
                end
                nframes++;
                if (!done_seen) frames_pre++;
            end
            if (e_lf) begin
                chk(wide_enough(lrise_age), "R6 latch high", lrise_age, HF);
                if (cfg_fall_cyc < 0) cfg_fall_cyc = cyc;
                nbits = 0;
            end
            if (wr_ready) chk(amp_mute_n && !ser_clk && !ser_latch, "R8 ready state", amp_mute_n, 1);
            if (done_seen && !(amp_rst_n && amp_pwr_n && amp_mute_n && done)) sticky_bad = 1;
            if (amp_mute_n && !p_mute) begin
                chk(cfg_fall_cyc >= 0 && cyc - cfg_fall_cyc >= MC, "R7 mute delay", cyc - cfg_fall_cyc, MC);
                chk(done, "R7 done with mute", done, 1);
                done_seen = 1;
            end
        end
        p_clk = ser_clk; p_dat = ser_dat; p_lat = ser_latch;
        p_rst = amp_rst_n; p_pwr = amp_pwr_n; p_mute = amp_mute_n;
    end

    task automatic do_write(input logic [15:0] d);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        #1 wr_valid = 1'b1;
        wr_data = d;
        expq.push_back(d);
        @(negedge clk);
        chk(!wr_ready, "R8 ready drops", wr_ready, 0);
        #1 wr_valid = 1'b0;
    endtask

    int writes = 0;

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        expq.push_back(init_word);
        // R9: request during startup must be ignored
        wr_valid = 1'b1;
        wr_data  = 16'hFFFF;
        while (cfg_fall_cyc < 0) @(negedge clk);
        #1 wr_valid = 1'b0;
        while (!done) @(negedge clk);
        do_write(16'h0000); writes++;
        do_write(16'hFFFF); writes++;
        do_write(16'h8001); writes++;
        for (int i = 0; i < 20; i++) begin
            do_write(16'($urandom)); writes++;
            if ($urandom % 2 == 1) begin
                for (int k = 0; k < 6; k++) begin
                    @(negedge clk);
                    #1 wr_valid = 1'b1;
                    wr_data = 16'($urandom);
                end
                @(negedge clk);
                #1 wr_valid = 1'b0;
            end
        end
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        repeat (frame_len() / 8) @(negedge clk);
        chk(nframes == writes + 1, "R9 frame total", nframes, writes + 1);
        chk(expq.size() == 0, "R4 all frames seen", expq.size(), 0);
        chk(frames_pre == 1, "R9 startup frames", frames_pre, 1);
        chk(!sticky_bad, "R10 lines steady", sticky_bad, 0);
        chk(done_seen, "R7 done reached", done_seen, 1);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end
endmodule